// File: doc/BRIEF.md
# Panel Configuration Register Slave

This block is the serial slave behind a small display controller's configuration space. A host reaches it over a four-wire serial link in mode 0, most significant bit first, with an active-low select. Each access opens with an 8-bit address byte whose top bit sets the direction. When that bit is clear, a second byte follows and is written to the register. When it is set, the slave shifts the register's contents back during the second byte.

The register file holds trims for three supply levels, the scan-direction and input-format word, the rail and standby controls, the two back porches, the signal polarities, the sync and inversion mode, and eight gamma pairs. Every field is decoded onto its own output pin for the panel logic downstream. Writing a word with bit 0 cleared to the soft-reset address puts the whole file back to its defaults and raises a single-cycle pulse.

The serial pins are resampled in the system clock domain. Everything, including the returned data, is produced from the system clock.

Top module: `panel_cfg_spi`

## Requirements
- R1: An address byte with bit 7 = 0, followed by a data byte (16 clock edges in total, most significant bit first), writes that data to the register at address bits 6:0.
- R2: An address byte with bit 7 = 1 causes the register value to appear on `spi_miso` during the next eight clocks. The most significant bit is valid before the first rising edge of the second byte, and each following bit changes on a falling edge.
- R3: Address 0x00 always reads 0x96, and writes to it have no effect.
- R4: After reset, registers read as follows: 0x01 = 0x0F, 0x02 = 0x2E, 0x03 = 0x12, 0x06 = 0x0F, 0x07 = 0xFE, 0x0A = 0x09, and 0x08, 0x09, 0x0B and 0x10 to 0x17 = 0x00.
- R5: Writing address 0x04 with bit 0 = 0 restores every register to its R4 default and pulses `soft_rst` high for exactly one clock. Writing 0x04 with bit 0 = 1 does nothing. Address 0x04 always reads 0x00.
- R6: Register 0x06 fields drive the outputs: bit 0 drives `scan_h_ltr`, bit 1 drives `scan_v_ttb`, bits 3:2 drive `video_std`, and bits 7:4 drive `in_fmt`. `in_disabled` is high for format codes 4, 9 and 12 to 15.
- R7: Register 0x07 fields drive the outputs: bit 0 drives `pwr_normal`, bits 5:1 drive `rail_en`, and bit 6 drives `pwr_auto`.
- R8: Register 0x0A bits 0 to 6 drive `pol_dclk`, `pol_hsync`, `pol_vsync`, `pol_de`, `chroma_swap`, `conv_formula` and `data_invert`, in that order. Register 0x0B bits 3:2 drive `sync_mode` and bit 0 drives `line_inv`.
- R9: Register 0x10+i (i = 0 to 7) appears on `gamma_cfg[8i+7:8i]`, with the negative value in the upper nibble and the positive value in the lower nibble.
- R10: Register 0x08 keeps only bits 5:0 and reads 0 in bits 7:6. Register 0x09 drives `hbp`. Unimplemented addresses in 0x05 to 0x7F read 0x00 and ignore writes.
- R11: A transfer with fewer than 16 clocks changes nothing. Clocks beyond the 16th are ignored. A read transfer never writes, whatever is sent in its second byte.
- R12: `spi_miso` is 0 whenever the select is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock, mode 0 |
| spi_csn | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| soft_rst | output | 1 | One-cycle pulse on register-file soft reset |
| trim_amp | output | 8 | Amplitude trim |
| trim_high | output | 8 | High-level trim |
| trim_vreg | output | 8 | Regulator trim |
| scan_h_ltr | output | 1 | Horizontal scan left-to-right |
| scan_v_ttb | output | 1 | Vertical scan top-to-bottom |
| video_std | output | 2 | Video standard select |
| in_fmt | output | 4 | Input format code |
| in_disabled | output | 1 | Input format is a disabled code |
| pwr_normal | output | 1 | Normal (1) or standby (0) |
| rail_en | output | 5 | Supply rail enables |
| pwr_auto | output | 1 | Automatic power sequencing |
| vbp | output | 6 | Vertical back porch |
| hbp | output | 8 | Horizontal back porch |
| pol_dclk | output | 1 | Pixel clock polarity |
| pol_hsync | output | 1 | Horizontal sync polarity |
| pol_vsync | output | 1 | Vertical sync polarity |
| pol_de | output | 1 | Data-enable polarity |
| chroma_swap | output | 1 | Colour/chroma order swap |
| conv_formula | output | 1 | Colour conversion formula select |
| data_invert | output | 1 | Data inversion |
| sync_mode | output | 2 | Sync mode select |
| line_inv | output | 1 | Line (1) or frame (0) inversion |
| gamma_cfg | output | 64 | Eight gamma bytes, register 0x10 in the low byte |

## Verification
Each serial pin passes through two sampling flops and one edge-detect flop. A committed write therefore reaches the field outputs three system clocks after the 16th rising serial-clock edge. Returned data changes on `spi_miso` three system clocks after the serial-clock edge that launches it. The bench holds each serial-clock phase for six system clocks and samples `spi_miso` just before each rising edge, so every bit is settled when it is read. Field outputs and `soft_rst` pulse counts are checked only after the select has been high for many cycles, well beyond the three-cycle pipeline.

// File: rtl/panel_cfg_spi.sv
module panel_cfg_spi #(
  parameter int         GAMMA_N     = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] ID_CODE     = 8'h96
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 spi_sclk,
  input  logic                 spi_csn,
  input  logic                 spi_mosi,
  output logic                 spi_miso,
  output logic                 soft_rst,
  output logic [7:0]           trim_amp,
  output logic [7:0]           trim_high,
  output logic [7:0]           trim_vreg,
  output logic                 scan_h_ltr,
  output logic                 scan_v_ttb,
  output logic [1:0]           video_std,
  output logic [3:0]           in_fmt,
  output logic                 in_disabled,
  output logic                 pwr_normal,
  output logic [4:0]           rail_en,
  output logic                 pwr_auto,
  output logic [5:0]           vbp,
  output logic [7:0]           hbp,
  output logic                 pol_dclk,
  output logic                 pol_hsync,
  output logic                 pol_vsync,
  output logic                 pol_de,
  output logic                 chroma_swap,
  output logic                 conv_formula,
  output logic                 data_invert,
  output logic [1:0]           sync_mode,
  output logic                 line_inv,
  output logic [8*GAMMA_N-1:0] gamma_cfg
);
  localparam logic [6:0] A_AMP  = 7'h01, A_HIGH = 7'h02, A_VREG = 7'h03, A_RST = 7'h04;
  localparam logic [6:0] A_ENTR = 7'h06, A_PWR  = 7'h07, A_VBP  = 7'h08, A_HBP = 7'h09;
  localparam logic [6:0] A_POL  = 7'h0A, A_IFC  = 7'h0B, A_GAM  = 7'h10;
  localparam logic [7:0] D_AMP = 8'h0F, D_HIGH = 8'h2E, D_VREG = 8'h12;
  localparam logic [7:0] D_ENTR = 8'h0F, D_PWR = 8'hFE, D_POL = 8'h09;
  localparam int         CW = 5;
  localparam logic [CW-1:0] LAST_BIT = CW'(15);
  localparam logic [CW-1:0] DONE_CNT = CW'(16);

  logic [SYNC_STAGES-1:0] cs_sh, ck_sh, mo_sh;
  logic ck_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_sh <= '1; ck_sh <= '0; mo_sh <= '0; ck_q <= 1'b0;
    end else begin
      cs_sh <= {cs_sh[SYNC_STAGES-2:0], spi_csn};
      ck_sh <= {ck_sh[SYNC_STAGES-2:0], spi_sclk};
      mo_sh <= {mo_sh[SYNC_STAGES-2:0], spi_mosi};
      ck_q  <= ck_sh[SYNC_STAGES-1];
    end

  wire cs_act = !cs_sh[SYNC_STAGES-1];
  wire ck_s   = ck_sh[SYNC_STAGES-1];
  wire mo_s   = mo_sh[SYNC_STAGES-1];
  wire rise   = cs_act && ck_s && !ck_q;
  wire fall   = cs_act && !ck_s && ck_q;

  logic [CW-1:0] bit_cnt;
  logic [6:0]    shreg;
  logic [7:0]    addr, tx;
  wire  [7:0]    in_byte = {shreg, mo_s};

  logic [7:0] r_amp, r_high, r_vreg, r_entr, r_pwr, r_hbp, r_pol, r_ifc;
  logic [5:0] r_vbp;
  logic [7:0] r_gam [GAMMA_N];

  function automatic logic [7:0] rd_mux(input logic [6:0] a);
    logic [7:0] d;
    d = 8'h00;
    case (a)
      7'h00:  d = ID_CODE;
      A_AMP:  d = r_amp;
      A_HIGH: d = r_high;
      A_VREG: d = r_vreg;
      A_ENTR: d = r_entr;
      A_PWR:  d = r_pwr;
      A_VBP:  d = {2'b00, r_vbp};
      A_HBP:  d = r_hbp;
      A_POL:  d = r_pol;
      A_IFC:  d = r_ifc;
      default: d = 8'h00;
    endcase
    for (int i = 0; i < GAMMA_N; i++)
      if (a == A_GAM + 7'(i)) d = r_gam[i];
    return d;
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bit_cnt <= '0; shreg <= '0; addr <= '0; tx <= '0;
    end else if (!cs_act) begin
      bit_cnt <= '0; tx <= '0;
    end else begin
      if (rise && bit_cnt != DONE_CNT) begin
        shreg   <= in_byte[6:0];
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == CW'(7)) begin
          addr <= in_byte;
          if (in_byte[7]) tx <= rd_mux(in_byte[6:0]);
        end
      end
      if (fall && bit_cnt >= CW'(9) && bit_cnt <= DONE_CNT)
        tx <= {tx[6:0], 1'b0};
    end

  assign spi_miso = cs_act && tx[7];

  wire wr_fire = rise && bit_cnt == LAST_BIT && !addr[7];
  wire [6:0] wa = addr[6:0];
  wire do_rst = wr_fire && wa == A_RST && !in_byte[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      r_amp <= D_AMP; r_high <= D_HIGH; r_vreg <= D_VREG; r_entr <= D_ENTR;
      r_pwr <= D_PWR; r_vbp <= '0; r_hbp <= '0; r_pol <= D_POL; r_ifc <= '0;
      soft_rst <= 1'b0;
    end else begin
      soft_rst <= do_rst;
      if (do_rst) begin
        r_amp <= D_AMP; r_high <= D_HIGH; r_vreg <= D_VREG; r_entr <= D_ENTR;
        r_pwr <= D_PWR; r_vbp <= '0; r_hbp <= '0; r_pol <= D_POL; r_ifc <= '0;
      end else if (wr_fire) begin
        case (wa)
          A_AMP:  r_amp  <= in_byte;
          A_HIGH: r_high <= in_byte;
          A_VREG: r_vreg <= in_byte;
          A_ENTR: r_entr <= in_byte;
          A_PWR:  r_pwr  <= in_byte;
          A_VBP:  r_vbp  <= in_byte[5:0];
          A_HBP:  r_hbp  <= in_byte;
          A_POL:  r_pol  <= in_byte;
          A_IFC:  r_ifc  <= in_byte;
          default: ;
        endcase
      end
    end

  for (genvar g = 0; g < GAMMA_N; g++) begin : g_gam
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                                     r_gam[g] <= '0;
      else if (do_rst)                                r_gam[g] <= '0;
      else if (wr_fire && wa == A_GAM + 7'(g))        r_gam[g] <= in_byte;
    assign gamma_cfg[8*g +: 8] = r_gam[g];
  end

  assign trim_amp     = r_amp;
  assign trim_high    = r_high;
  assign trim_vreg    = r_vreg;
  assign scan_h_ltr   = r_entr[0];
  assign scan_v_ttb   = r_entr[1];
  assign video_std    = r_entr[3:2];
  assign in_fmt       = r_entr[7:4];
  assign in_disabled  = in_fmt == 4'd4 || in_fmt == 4'd9 || in_fmt >= 4'd12;
  assign pwr_normal   = r_pwr[0];
  assign rail_en      = r_pwr[5:1];
  assign pwr_auto     = r_pwr[6];
  assign vbp          = r_vbp;
  assign hbp          = r_hbp;
  assign pol_dclk     = r_pol[0];
  assign pol_hsync    = r_pol[1];
  assign pol_vsync    = r_pol[2];
  assign pol_de       = r_pol[3];
  assign chroma_swap  = r_pol[4];
  assign conv_formula = r_pol[5];
  assign data_invert  = r_pol[6];
  assign sync_mode    = r_ifc[3:2];
  assign line_inv     = r_ifc[0];
endmodule

// File: rtl/panel_cfg_spi_chk.sv
module panel_cfg_spi_chk #(
  parameter int GAMMA_N = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 spi_csn,
  input logic                 spi_miso,
  input logic                 soft_rst,
  input logic [7:0]           trim_amp,
  input logic [7:0]           trim_high,
  input logic [7:0]           trim_vreg,
  input logic [3:0]           in_fmt,
  input logic [5:0]           vbp,
  input logic [7:0]           hbp,
  input logic                 pol_dclk,
  input logic                 pol_de,
  input logic [8*GAMMA_N-1:0] gamma_cfg
);
  AST_SOFT_RST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !soft_rst); // R5
  AST_SOFT_RST_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> (trim_amp == 8'h0F && trim_high == 8'h2E && trim_vreg == 8'h12 &&
                  in_fmt == 4'd0 && vbp == 6'd0 && hbp == 8'd0 &&
                  pol_dclk && pol_de && gamma_cfg == '0)); // R5
  AST_SOFT_RST_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> !$past(spi_csn, 3)); // R5
  AST_MISO_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_csn && $past(spi_csn) && $past(spi_csn, 2) && $past(spi_csn, 3)) |-> !spi_miso); // R12
  AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_csn && $past(spi_csn) && $past(spi_csn, 2) && $past(spi_csn, 3)) |->
      ($stable(trim_amp) && $stable(hbp) && $stable(vbp) && $stable(gamma_cfg))); // R11
endmodule

bind panel_cfg_spi panel_cfg_spi_chk #(.GAMMA_N(GAMMA_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .spi_csn(spi_csn), .spi_miso(spi_miso),
  .soft_rst(soft_rst), .trim_amp(trim_amp), .trim_high(trim_high),
  .trim_vreg(trim_vreg), .in_fmt(in_fmt), .vbp(vbp), .hbp(hbp),
  .pol_dclk(pol_dclk), .pol_de(pol_de), .gamma_cfg(gamma_cfg)
);

// File: tb/panel_cfg_spi_bench.sv
`timescale 1ns/1ps
module panel_cfg_spi_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;

  logic clk = 0, rst_n = 0, sclk = 0, csn = 1, mosi = 0;
  logic miso, soft_rst;
  logic [7:0] trim_amp, trim_high, trim_vreg, hbp;
  logic scan_h_ltr, scan_v_ttb, in_disabled, pwr_normal, pwr_auto;
  logic [1:0] video_std, sync_mode;
  logic [3:0] in_fmt;
  logic [4:0] rail_en;
  logic [5:0] vbp;
  logic pol_dclk, pol_hsync, pol_vsync, pol_de, chroma_swap, conv_formula, data_invert, line_inv;
  logic [63:0] gamma_cfg;

  always #(CLK_PERIOD/2) clk = ~clk;

  panel_cfg_spi u_panel_cfg_spi (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_csn(csn), .spi_mosi(mosi),
    .spi_miso(miso), .soft_rst(soft_rst), .trim_amp(trim_amp), .trim_high(trim_high),
    .trim_vreg(trim_vreg), .scan_h_ltr(scan_h_ltr), .scan_v_ttb(scan_v_ttb),
    .video_std(video_std), .in_fmt(in_fmt), .in_disabled(in_disabled),
    .pwr_normal(pwr_normal), .rail_en(rail_en), .pwr_auto(pwr_auto), .vbp(vbp),
    .hbp(hbp), .pol_dclk(pol_dclk), .pol_hsync(pol_hsync), .pol_vsync(pol_vsync),
    .pol_de(pol_de), .chroma_swap(chroma_swap), .conv_formula(conv_formula),
    .data_invert(data_invert), .sync_mode(sync_mode), .line_inv(line_inv),
    .gamma_cfg(gamma_cfg));

  int n_chk = 0, n_bad = 0, pulses = 0;
  logic [7:0] mdl [128];

  always @(posedge clk) if (soft_rst) pulses++;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic bit implemented(input int a);
    return a inside {1, 2, 3, 6, 7, 8, 9, 10, 11} || (a >= 16 && a <= 23);
  endfunction

  task automatic model_defaults();
    for (int a = 0; a < 128; a++) mdl[a] = 8'h00;
    mdl[0] = 8'h96; mdl[1] = 8'h0F; mdl[2] = 8'h2E; mdl[3] = 8'h12;
    mdl[6] = 8'h0F; mdl[7] = 8'hFE; mdl[10] = 8'h09;
  endtask

  task automatic model_write(input int a, input logic [7:0] d);
    if (a == 4 && !d[0]) model_defaults();
    else if (implemented(a)) mdl[a] = (a == 8) ? (d & 8'h3F) : d;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [31:0] bits, input int n, output logic [7:0] rx);
    rx = 0;
    csn = 0; idle(HALF);
    for (int i = 0; i < n; i++) begin
      mosi = bits[n-1-i];
      idle(HALF);
      if (i >= 8 && i < 16) rx = {rx[6:0], miso};
      sclk = 1; idle(HALF);
      sclk = 0;
    end
    idle(HALF); csn = 1; mosi = 0; idle(4*HALF);
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    logic [7:0] dummy;
    xfer({16'h0, 1'b0, 7'(a), d}, 16, dummy);
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    xfer({16'h0, 1'b1, 7'(a), 8'hA5}, 16, d);
  endtask

  task automatic sweep_read(input string req);
    logic [7:0] d;
    for (int a = 0; a < 128; a++) begin
      rd(a, d);
      check(req, d, mdl[a]);
    end
  endtask

  task automatic check_fields();
    check("R6 entry fields", {in_fmt, video_std, scan_v_ttb, scan_h_ltr}, mdl[6]);
    check("R7 power fields", {1'b0, pwr_auto, rail_en, pwr_normal}, mdl[7] & 8'h7F);
    check("R8 polarity fields", {1'b0, data_invert, conv_formula, chroma_swap, pol_de,
                                 pol_vsync, pol_hsync, pol_dclk}, mdl[10] & 8'h7F);
    check("R8 interface fields", {sync_mode, line_inv}, {mdl[11][3:2], mdl[11][0]});
    check("R10 porch vbp", vbp, mdl[8]);
    check("R10 porch hbp", hbp, mdl[9]);
    check("R4 trims", {trim_amp, trim_high, trim_vreg}, {mdl[1], mdl[2], mdl[3]});
    for (int i = 0; i < 8; i++) check("R9 gamma byte", gamma_cfg[8*i +: 8], mdl[16+i]);
  endtask

  initial begin
    logic [7:0] d;
    model_defaults();
    idle(5); rst_n = 1; idle(5);
    check("R12 miso idle", miso, 0);
    check("R5 no pulse at reset", soft_rst, 0);
    check_fields();
    sweep_read("R4 R3 R10 default read");

    for (int a = 0; a < 128; a++) begin
      logic [7:0] v = 8'((a * 37 + 5) ^ 8'hC3);
      if (a == 4) continue;
      wr(a, v); model_write(a, v);
    end
    sweep_read("R1 R2 R3 R10 readback");
    check_fields();
    check("R5 no pulse from sweep", pulses, 0);

    for (int f = 0; f < 16; f++) begin
      wr(6, 8'(f << 4)); model_write(6, 8'(f << 4));
      check("R6 in_disabled", in_disabled, (f == 4 || f == 9 || f >= 12));
      check("R6 in_fmt", in_fmt, f);
    end

    xfer({20'h0, 1'b0, 7'h09, 4'h5}, 12, d);
    check("R11 aborted write", hbp, mdl[9]);
    xfer({12'h0, 1'b0, 7'h09, 8'h3C, 4'hF}, 20, d);
    model_write(9, 8'h3C);
    check("R11 long write keeps first byte", hbp, 8'h3C);
    xfer({16'h0, 1'b1, 7'h09, 8'h77}, 16, d);
    check("R11 read does not write", hbp, 8'h3C);
    check("R2 read data", d, 8'h3C);
    rd(4, d);
    check("R5 reset reg reads zero", d, 0);

    wr(4, 8'hFF);
    check("R5 bit0 set no pulse", pulses, 0);
    check("R5 bit0 set keeps regs", hbp, 8'h3C);
    wr(4, 8'hFE); model_write(4, 8'hFE);
    check("R5 one pulse", pulses, 1);
    check_fields();
    sweep_read("R5 defaults after soft reset");
    check("R12 miso idle end", miso, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule